// File: doc/BRIEF.md
# Counter Bank Byte Read Interface

This block sits between a byte-wide host bus and a bank of four 16-bit event counters. The host uses two register addresses, called A and B. Writing A picks which counter is visible. Writing B sends a one-cycle clear strobe to a counter. Reading A returns the low byte of the picked counter. Reading B returns the high byte.

The counters keep running while the host reads them one byte at a time. A read of A therefore copies the whole count into a holding register in a single clock cycle. Every following byte comes from that copy. Adjacent counters can be joined in pairs to form 32-bit counts, one configuration bit per pair. When a pair is joined, a read of A on the low-order channel copies both halves at once. A read of A on the high-order channel does not take a new copy. It serves the upper half of the copy already held.

A clear strobe acts only on the live counters and never on the held copy. Software can therefore restart a counter right after the first byte read, while it is still fetching the remaining bytes.

Top module: `cnt_host_if`

## Requirements
- R1: While reset is high, and in the cycle after it, `rd_data` is 0 and no clear strobe is active. The selected channel after reset is channel 0.
- R2: A write to address A sets the selected channel to `bus_wdata[1:0]`. The upper data bits are ignored, so writing 5 selects channel 1.
- R3: A write to address B with `bus_wdata[1:0]` = n raises `clr_strobe[n]` for exactly one cycle, in the cycle after the write. No strobe is raised without such a write.
- R4: Channels 0 and 1 form pair 0, controlled by `join_cfg[0]`. Channels 2 and 3 form pair 1, controlled by `join_cfg[1]`. When a pair is joined, a clear of its even (low-order) channel strobes both channels of the pair. A clear of its odd channel strobes only the odd channel.
- R5: A read of A on a channel that is unjoined, or on the even channel of a joined pair, captures that channel's count into the holding register. In the next cycle `rd_data` shows bits 7:0 of the count as it was in the read cycle.
- R6: A read of B puts bits 15:8 of the held copy on `rd_data` one cycle later. The result does not depend on how the live count has moved since the copy was taken.
- R7: In a joined pair, a read of A on the even channel captures the odd channel's count as bits 31:16 of the held copy, in the same cycle as the even channel's count.
- R8: In a joined pair, a read of A while the odd channel is selected takes no new copy and returns bits 23:16 of the held copy. The next read of B returns bits 31:24.
- R9: A clear strobe never alters the held copy. Bytes read after a clear still come from the earlier capture.
- R10: A read of B before any read of A since reset returns 0.
- R11: `rd_data` holds its value in every cycle without a read.
- R12: The pairs are configured independently. An unjoined pair behaves as two 16-bit channels while the other pair is joined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_a | input | 1 | Access targets address A |
| bus_sel_b | input | 1 | Access targets address B |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| cnt_vals | input | 64 | Live counts; channel c occupies bits 16c+15:16c |
| join_cfg | input | 2 | Bit p joins channels 2p and 2p+1 into a 32-bit count |
| clr_strobe | output | 4 | One-cycle clear request per counter |
| rd_data | output | 8 | Registered read data, valid the cycle after a read |

## Verification
Most faults inside this block show up on the ports within one cycle. A wrong selected channel, a bad byte lane or a missing capture changes `rd_data` on the very next read. A stray or mis-targeted clear appears on `clr_strobe` in the cycle after the write. A corrupted holding register is the exception. It stays hidden until the following read of B, or the read of A on the odd channel, so the bench lets the counters run between capture and byte reads. It also issues clears in the middle of sequences, so that a copy overwritten by a clear or by a later read returns a byte different from the one captured.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEL,
    OP_CLR,
    OP_RD_LO,
    OP_RD_HI
  } bus_op_e;
endpackage

// File: rtl/cnt_host_decode.sv
module cnt_host_decode
  import cnt_host_pkg::*;
(
  input  logic    bus_sel_a,
  input  logic    bus_sel_b,
  input  logic    bus_wr,
  input  logic    bus_rd,
  output bus_op_e op
);
  // Reads win over writes; address A wins over B when both are flagged.
  always_comb begin
    op = OP_NONE;
    if (bus_rd && bus_sel_a)      op = OP_RD_LO;
    else if (bus_rd && bus_sel_b) op = OP_RD_HI;
    else if (bus_wr && bus_sel_a) op = OP_SEL;
    else if (bus_wr && bus_sel_b) op = OP_CLR;
  end
endmodule

// File: rtl/cnt_host_ctrl.sv
module cnt_host_ctrl
  import cnt_host_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  localparam int SW    = $clog2(NUM_CH),
  localparam int NPAIR = NUM_CH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           op,
  input  logic [DW-1:0]     wdata,
  input  logic [NPAIR-1:0]  join_cfg,
  output logic [SW-1:0]     sel_q,
  output logic [NUM_CH-1:0] clr_q
);
  logic [SW-1:0] idx;
  assign idx = wdata[SW-1:0];

  always_ff @(posedge clk) begin
    if (rst)               sel_q <= '0;
    else if (op == OP_SEL) sel_q <= idx;
  end

  // Clear decode: the odd channel of a joined pair follows its even partner.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    logic hit;
    if ((c % 2) == 0) begin : g_even
      assign hit = (idx == SW'(c));
    end else begin : g_odd
      assign hit = (idx == SW'(c)) || (join_cfg[c/2] && (idx == SW'(c - 1)));
    end
    always_ff @(posedge clk) begin
      if (rst) clr_q[c] <= 1'b0;
      else     clr_q[c] <= (op == OP_CLR) && hit;
    end
  end
endmodule

// File: rtl/cnt_host_snap.sv
module cnt_host_snap
  import cnt_host_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  localparam int CW    = 2 * DW,
  localparam int SNW   = 2 * CW,
  localparam int SW    = $clog2(NUM_CH),
  localparam int NPAIR = NUM_CH / 2,
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  bus_op_e            op,
  input  logic [SW-1:0]      sel_q,
  input  logic [NUM_CH*CW-1:0] cnt_vals,
  input  logic [NPAIR-1:0]   join_cfg,
  output logic [DW-1:0]      rd_data,
  output logic [SNW-1:0]     snap_q
);
  logic [CW-1:0] ch_cnt [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign ch_cnt[c] = cnt_vals[c*CW +: CW];
  end

  logic [PW-1:0] pair_idx;
  logic [SW-1:0] part_idx;
  logic          pair_join;
  logic          odd_of_join;
  logic [CW-1:0] cur_cnt;
  logic [CW-1:0] part_cnt;
  logic          upper_q;

  assign pair_idx    = PW'(sel_q >> 1);
  assign part_idx    = sel_q | SW'(1);
  assign pair_join   = join_cfg[pair_idx];
  assign odd_of_join = pair_join && sel_q[0];
  assign cur_cnt     = ch_cnt[sel_q];
  assign part_cnt    = ch_cnt[part_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      upper_q <= 1'b0;
      rd_data <= '0;
    end else begin
      case (op)
        OP_RD_LO: begin
          if (odd_of_join) begin
            upper_q <= 1'b1;
            rd_data <= snap_q[CW +: DW];
          end else begin
            upper_q <= 1'b0;
            rd_data <= cur_cnt[DW-1:0];
            snap_q  <= pair_join ? {part_cnt, cur_cnt} : {{CW{1'b0}}, cur_cnt};
          end
        end
        OP_RD_HI: rd_data <= upper_q ? snap_q[CW+DW +: DW] : snap_q[DW +: DW];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cnt_host_if.sv
module cnt_host_if
  import cnt_host_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  localparam int CW    = 2 * DW,
  localparam int SNW   = 2 * CW,
  localparam int SW    = $clog2(NUM_CH),
  localparam int NPAIR = NUM_CH / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel_a,
  input  logic                 bus_sel_b,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  input  logic [NUM_CH*CW-1:0] cnt_vals,
  input  logic [NPAIR-1:0]     join_cfg,
  output logic [NUM_CH-1:0]    clr_strobe,
  output logic [DW-1:0]        rd_data
);
  bus_op_e        op;
  logic [SW-1:0]  sel_q;
  logic [SNW-1:0] snap_q;

  cnt_host_decode u_dec (
    .bus_sel_a (bus_sel_a),
    .bus_sel_b (bus_sel_b),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .op        (op)
  );

  cnt_host_ctrl #(.NUM_CH(NUM_CH), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wdata    (bus_wdata),
    .join_cfg (join_cfg),
    .sel_q    (sel_q),
    .clr_q    (clr_strobe)
  );

  cnt_host_snap #(.NUM_CH(NUM_CH), .DW(DW)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .sel_q    (sel_q),
    .cnt_vals (cnt_vals),
    .join_cfg (join_cfg),
    .rd_data  (rd_data),
    .snap_q   (snap_q)
  );
endmodule

// File: rtl/cnt_host_if_chk.sv
module cnt_host_if_chk #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  localparam int CW    = 2 * DW,
  localparam int SNW   = 2 * CW,
  localparam int SW    = $clog2(NUM_CH),
  localparam int NPAIR = NUM_CH / 2,
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel_a,
  input logic                 bus_sel_b,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [NUM_CH*CW-1:0] cnt_vals,
  input logic [NPAIR-1:0]     join_cfg,
  input logic [NUM_CH-1:0]    clr_strobe,
  input logic [DW-1:0]        rd_data,
  input logic [SW-1:0]        sel_q,
  input logic [SNW-1:0]       snap_q
);
  logic [CW-1:0] c_cnt [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assign c_cnt[c] = cnt_vals[c*CW +: CW];
  end

  logic          odd_join;
  logic [DW-1:0] live_lo;
  logic          rd_lo, rd_hi, wr_clr;
  assign odd_join = join_cfg[PW'(sel_q >> 1)] && sel_q[0];
  assign live_lo  = c_cnt[sel_q][DW-1:0];
  assign rd_lo    = bus_rd && bus_sel_a;
  assign rd_hi    = bus_rd && bus_sel_b && !bus_sel_a;
  assign wr_clr   = bus_wr && bus_sel_b && !bus_sel_a && !bus_rd;

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && clr_strobe == '0));

  // R3
  assert_strobe_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_strobe != '0) |-> $past(wr_clr));

  // R4
  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(clr_strobe) <= 2);

  // R5
  assert_low_read_live_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !odd_join) |=> (rd_data == $past(live_lo)));

  // R8
  assert_odd_read_no_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && odd_join) |=> $stable(snap_q));

  // R9
  assert_clear_keeps_copy_R9: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> $stable(snap_q));

  // R6
  assert_high_read_no_capture_R6: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> $stable(snap_q));

  // R11
  assert_data_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rd_data));
endmodule

bind cnt_host_if cnt_host_if_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel_a  (bus_sel_a),
  .bus_sel_b  (bus_sel_b),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .cnt_vals   (cnt_vals),
  .join_cfg   (join_cfg),
  .clr_strobe (clr_strobe),
  .rd_data    (rd_data),
  .sel_q      (sel_q),
  .snap_q     (snap_q)
);

// File: tb/cnt_host_if_tb.sv
`timescale 1ns/1ps
module cnt_host_if_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel_a, bus_sel_b, bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [1:0]  join_cfg;
  logic [3:0]  clr_strobe;
  logic [7:0]  rd_data;
  logic [15:0] cnt [4];
  logic [15:0] inc [4];
  logic [63:0] cnt_vals;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_sel;
  logic [31:0] m_snap;
  bit          m_up;
  logic [7:0]  m_rd;
  logic [3:0]  m_clr;

  always #2 clk = ~clk;
  assign cnt_vals = {cnt[3], cnt[2], cnt[1], cnt[0]};

  cnt_host_if u_dut (
    .clk(clk), .rst(rst), .bus_sel_a(bus_sel_a), .bus_sel_b(bus_sel_b),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .cnt_vals(cnt_vals), .join_cfg(join_cfg),
    .clr_strobe(clr_strobe), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, model it, compare at the following negedge.
  task automatic step(input bit a, input bit b, input bit wr, input bit rd,
                      input logic [7:0] wd, input string tag);
    int n;
    bus_sel_a = a; bus_sel_b = b; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    m_clr = '0;
    if (rd && a) begin
      if (join_cfg[m_sel/2] && (m_sel % 2 == 1)) begin
        m_rd = m_snap[23:16]; m_up = 1;
      end else begin
        m_rd = cnt[m_sel][7:0]; m_up = 0;
        m_snap = join_cfg[m_sel/2] ? {cnt[m_sel+1], cnt[m_sel]} : {16'h0, cnt[m_sel]};
      end
    end else if (rd && b) begin
      m_rd = m_up ? m_snap[31:24] : m_snap[15:8];
    end else if (wr && a) begin
      m_sel = int'(wd[1:0]);
    end else if (wr && b) begin
      n = int'(wd[1:0]);
      m_clr[n] = 1'b1;
      if (join_cfg[n/2] && (n % 2 == 0)) m_clr[n+1] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rd_data"}, {24'h0, rd_data}, {24'h0, m_rd});
    chk({"R3 ", tag, " clr_strobe"}, {28'h0, clr_strobe}, {28'h0, m_clr});
    for (int i = 0; i < 4; i++) cnt[i] = clr_strobe[i] ? 16'h0 : cnt[i] + inc[i];
    bus_sel_a = 0; bus_sel_b = 0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, "R11 idle");
  endtask
  task automatic do_sel(input logic [7:0] v, input string tag); step(1, 0, 1, 0, v, tag); endtask
  task automatic do_clr(input logic [7:0] v, input string tag); step(0, 1, 1, 0, v, tag); endtask
  task automatic rd_a(input string tag, output logic [7:0] v);
    step(1, 0, 0, 1, 8'h00, tag); v = rd_data;
  endtask
  task automatic rd_b(input string tag, output logic [7:0] v);
    step(0, 1, 0, 1, 8'h00, tag); v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b0, b1, b2, b3;
    logic [31:0] want;
    rst = 1; bus_sel_a = 0; bus_sel_b = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    join_cfg = 2'b00;
    for (int i = 0; i < 4; i++) begin
      cnt[i] = 16'h1000 * 16'(i + 1) + 16'h00F0;
      inc[i] = 16'(i + 1);
    end
    m_sel = 0; m_snap = '0; m_up = 0; m_rd = '0; m_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rd_data", {24'h0, rd_data}, 32'h0);
    chk("R1 reset clr_strobe", {28'h0, clr_strobe}, 32'h0);
    rst = 0;
    idle(1);

    // R10: high byte before any capture
    rd_b("R10 B before A", b0);
    chk("R10 B before A zero", {24'h0, b0}, 32'h0);

    // R1: channel 0 selected after reset; R5/R6 16-bit read
    want = {16'h0, cnt[0]};
    rd_a("R1 R5 ch0 low", b0);
    idle(3);
    rd_b("R6 ch0 high", b1);
    chk("R6 ch0 assembled", {16'h0, b1, b0}, want);

    // R2: upper data bits ignored, 5 selects channel 1
    do_sel(8'h05, "R2 select via 5");
    want = {16'h0, cnt[1]};
    rd_a("R2 R5 ch1 low", b0);
    rd_b("R6 ch1 high", b1);
    chk("R2 ch1 value", {16'h0, b1, b0}, want);

    // R3: clears unjoined
    do_clr(8'hFE, "R3 clear ch2 via FE");
    do_clr(8'h01, "R3 clear ch1");
    idle(2);

    // R7, R8, R9: joined pair 0, clear right after the first read
    join_cfg = 2'b01;
    idle(1);
    cnt[0] = 16'hFFF8; cnt[1] = 16'h12FF;
    do_sel(8'h00, "R7 select even");
    want = {cnt[1], cnt[0]};
    rd_a("R7 joined low capture", b0);
    do_clr(8'h00, "R4 R9 clear joined pair");
    rd_b("R9 joined byte1", b1);
    do_sel(8'h01, "R8 select odd");
    idle(2);
    rd_a("R8 odd read bits 23:16", b2);
    rd_b("R8 odd read bits 31:24", b3);
    chk("R7 R8 32-bit assembled", {b3, b2, b1, b0}, want);

    // R4: clear of odd channel in a joined pair hits only that channel
    do_clr(8'h01, "R4 clear odd joined");

    // R12: pair 1 unjoined while pair 0 joined
    do_sel(8'h03, "R12 select ch3");
    want = {16'h0, cnt[3]};
    rd_a("R12 ch3 low", b0);
    rd_b("R12 ch3 high", b1);
    chk("R12 ch3 value", {16'h0, b1, b0}, want);
    do_clr(8'h02, "R12 clear ch2 unjoined");

    // R4/R12: join pair 1, clear its even channel
    join_cfg = 2'b11;
    idle(1);
    do_clr(8'h02, "R4 clear joined pair1");
    idle(4);
    do_sel(8'h02, "R7 select ch2");
    want = {cnt[3], cnt[2]};
    rd_a("R7 pair1 low", b0);
    rd_b("R6 pair1 byte1", b1);
    do_sel(8'h03, "R8 select ch3");
    rd_a("R8 pair1 byte2", b2);
    rd_b("R8 pair1 byte3", b3);
    chk("R7 pair1 assembled", {b3, b2, b1, b0}, want);

    // R11: data holds over idle cycles
    idle(5);
    chk("R11 hold", {24'h0, rd_data}, {24'h0, b3});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule